// File: doc/BRIEF.md
# Reset Cause Capture and Routing

This block keeps a sticky record of which reset source fired last and decides what each routable event turns into. The sources are a power-on detect, a 1.2V low-voltage detect for each of two core power domains, a 2.7V regulator low-voltage detect, and a set of functional event lines. A routable event becomes one of three things: a one-cycle functional reset request, a level SAFE-mode request, or a level interrupt request. The choice comes from two configuration registers.

The power-on flag is deliberately fragile. Any low-voltage detect wipes it, so a power-up that rises, sags and recovers leaves only the low-voltage flag behind. Software treats any of those flags as a power-on cause.

The core-domain-0 low-voltage event is special in two ways. It is taken when its detect line falls, not when it rises. It is also routed like a functional event through the top bit of the configuration registers. Software reaches the block over a small register bus that carries an access-mode tag.

The disable register is protected per byte. Each byte takes exactly one permitted write between power-on resets.

Top module: `rst_cause_router`

## Requirements
- R1: After the asynchronous power-on reset (`rst_n` low), every status flag, the disable register, the alternate register and all three request outputs are 0, and every disable byte is writable again.
- R2: A rising edge on `pwr_on_det` sets the power-on flag, which is bit 0 at address 0. The flag is visible on the read port one clock edge after the edge is seen.
- R3: A rising edge on any of `lv_core0_det`, `lv_core1_det` or `lv_reg_det` clears the power-on flag. This clear wins over a power-on edge seen in the same cycle.
- R4: Rising edges on `lv_core1_det` and `lv_reg_det` set the flags at address 0 bit 2 and bit 3 respectively.
- R5: The core-domain-0 flag (address 0 bit 1) is set on the falling edge of `lv_core0_det`. Its rising edge does not set it.
- R6: A rising edge on `func_evt[i]` sets flag bit i at address 1. If disable bit i is 0, `func_rst_req` is high for exactly one cycle, visible one edge after the event.
- R7: If disable bit i is 1, the event raises no reset request. Alternate bit i then selects the outcome: 0 gives `safe_req` and 1 gives `irq_req`.
- R8: The core-domain-0 event is routed by bit 15 of the disable and alternate registers. It requests a reset, or its alternate request, at the falling edge of `lv_core0_det`.
- R9: Writing 1 to a status bit clears it, but only from supervisor mode (`bus_mode` = 1). Writes from user (0) or test (2) mode leave the status unchanged. An event arriving in the same cycle as a clear leaves the flag set.
- R10: The disable register (address 2) and the alternate register (address 3) accept writes in supervisor or test mode. Writes in user mode, or with `bus_mode` = 3, are ignored. All addresses read combinationally on `bus_rdata` in any mode.
- R11: Each byte of the disable register, selected by `bus_be[b]`, takes only its first permitted write after power-on reset, even when that write is all zeros. Later writes to that byte are ignored. The alternate register has no such lock.
- R12: `safe_req` and `irq_req` stay asserted while a matching flag remains set, and drop when that flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pwr_on_det | input | 1 | Power-on detect, captured on rising edge |
| lv_core0_det | input | 1 | Core domain 0 low-voltage detect, captured on falling edge |
| lv_core1_det | input | 1 | Core domain 1 low-voltage detect |
| lv_reg_det | input | 1 | Regulator low-voltage detect |
| func_evt | input | 15 | Functional event lines |
| bus_wr | input | 1 | Register write strobe |
| bus_mode | input | 2 | Access mode: 0 user, 1 supervisor, 2 test |
| bus_addr | input | 2 | Register address: 0 power status, 1 event status, 2 disable, 3 alternate |
| bus_be | input | 2 | Byte enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| func_rst_req | output | 1 | One-cycle functional reset request |
| safe_req | output | 1 | SAFE-mode request level |
| irq_req | output | 1 | Interrupt request level |

## Verification
The bench aims at the orderings that are easy to get backwards.

- A power-on edge coinciding with a regulator detect must leave only the regulator flag set. A design that lets the power-on edge win would report power-on.
- The core-domain-0 detect is held high while the bench looks for a premature flag or reset pulse. A design that captures on assertion would show the flag too early.
- A zero write to a disable byte followed by a nonzero one exposes a lock that keys on the data value.
- A status clear issued in the same cycle as a new event exposes clear-over-set priority, which would lose an interrupt.
- A second power-on reset partway through the run shows whether the byte locks really reopen.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  typedef enum logic [1:0] {
    MODE_USER = 2'd0,
    MODE_SUPV = 2'd1,
    MODE_TEST = 2'd2,
    MODE_RSVD = 2'd3
  } acc_mode_e;

  localparam logic [1:0] ADDR_PWR  = 2'd0;
  localparam logic [1:0] ADDR_FUNC = 2'd1;
  localparam logic [1:0] ADDR_DIS  = 2'd2;
  localparam logic [1:0] ADDR_ALT  = 2'd3;

  localparam int PWR_W    = 4;
  localparam int BIT_POR  = 0;
  localparam int BIT_LV0  = 1;
  localparam int BIT_LV1  = 2;
  localparam int BIT_LV27 = 3;
endpackage

// File: rtl/rcr_edge.sv
module rcr_edge #(
  parameter int W      = 4,
  parameter bit RISING = 1'b1
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q, prev_d;

  always_comb prev_d = sig_i;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= prev_d;
  end

  generate
    if (RISING) begin : g_rise
      assign hit_o = sig_i & ~prev_q;
    end else begin : g_fall
      assign hit_o = ~sig_i & prev_q;
    end
  endgenerate
endmodule

// File: rtl/rcr_capture.sv
module rcr_capture
  import rcr_pkg::*;
#(
  parameter int NUM_FUNC = 15
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                pwr_on_i,
  input  logic                lv_c0_i,
  input  logic                lv_c1_i,
  input  logic                lv_reg_i,
  input  logic [NUM_FUNC-1:0] func_i,
  input  logic [PWR_W-1:0]    pwr_clr_i,
  input  logic [NUM_FUNC-1:0] func_clr_i,
  output logic [PWR_W-1:0]    pwr_flags_o,
  output logic [NUM_FUNC-1:0] func_flags_o,
  output logic [NUM_FUNC:0]   route_ev_o
);
  localparam int IN_W = NUM_FUNC + PWR_W;

  logic [IN_W-1:0]     rise;
  logic [0:0]          lv0_fall;
  logic [PWR_W-1:0]    pwr_q, pwr_d;
  logic [NUM_FUNC-1:0] func_q, func_d;
  logic [NUM_FUNC-1:0] func_rise;
  logic                lv_hit;

  rcr_edge #(.W(IN_W), .RISING(1'b1)) u_rise (
    .clk    (clk),
    .rst_ni (rst_ni),
    .sig_i  ({func_i, lv_reg_i, lv_c1_i, lv_c0_i, pwr_on_i}),
    .hit_o  (rise)
  );

  rcr_edge #(.W(1), .RISING(1'b0)) u_fall (
    .clk    (clk),
    .rst_ni (rst_ni),
    .sig_i  (lv_c0_i),
    .hit_o  (lv0_fall)
  );

  assign func_rise = rise[IN_W-1:PWR_W];
  assign lv_hit    = rise[1] | rise[2] | rise[3];

  always_comb begin
    pwr_d[BIT_POR]  = lv_hit ? 1'b0 : (rise[0] | (pwr_q[BIT_POR] & ~pwr_clr_i[BIT_POR]));
    pwr_d[BIT_LV0]  = lv0_fall[0] | (pwr_q[BIT_LV0]  & ~pwr_clr_i[BIT_LV0]);
    pwr_d[BIT_LV1]  = rise[2]     | (pwr_q[BIT_LV1]  & ~pwr_clr_i[BIT_LV1]);
    pwr_d[BIT_LV27] = rise[3]     | (pwr_q[BIT_LV27] & ~pwr_clr_i[BIT_LV27]);
    func_d          = func_rise   | (func_q & ~func_clr_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q  <= '0;
      func_q <= '0;
    end else begin
      pwr_q  <= pwr_d;
      func_q <= func_d;
    end
  end

  assign pwr_flags_o  = pwr_q;
  assign func_flags_o = func_q;
  assign route_ev_o   = {lv0_fall[0], func_rise};

  assert_por_cleared_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    lv_hit |=> !pwr_q[BIT_POR]);
  assert_lv0_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(pwr_q[BIT_LV0]) |-> !$past(lv_c0_i));
  assert_lv1_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(pwr_q[BIT_LV1]) |-> $past(lv_c1_i));
  assert_event_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (|func_rise) |=> (|func_q));
endmodule

// File: rtl/rcr_cfg.sv
module rcr_cfg
  import rcr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            bus_wr_i,
  input  logic [1:0]      bus_mode_i,
  input  logic [1:0]      bus_addr_i,
  input  logic [DW/8-1:0] bus_be_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   dis_o,
  output logic [DW-1:0]   alt_o
);
  localparam int NB = DW / 8;

  logic [DW-1:0] dis_q, dis_d, alt_q, alt_d;
  logic [NB-1:0] lock_q, lock_d;
  logic          mode_ok, dis_we, alt_we;

  always_comb begin
    mode_ok = (acc_mode_e'(bus_mode_i) == MODE_SUPV) || (acc_mode_e'(bus_mode_i) == MODE_TEST);
    dis_we  = bus_wr_i && mode_ok && (bus_addr_i == ADDR_DIS);
    alt_we  = bus_wr_i && mode_ok && (bus_addr_i == ADDR_ALT);
    dis_d   = dis_q;
    alt_d   = alt_q;
    lock_d  = lock_q;
    for (int b = 0; b < NB; b++) begin
      if (dis_we && bus_be_i[b] && !lock_q[b]) begin
        dis_d[b*8 +: 8] = bus_wdata_i[b*8 +: 8];
        lock_d[b]       = 1'b1;
      end
      if (alt_we && bus_be_i[b]) begin
        alt_d[b*8 +: 8] = bus_wdata_i[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q  <= '0;
      alt_q  <= '0;
      lock_q <= '0;
    end else begin
      dis_q  <= dis_d;
      alt_q  <= alt_d;
      lock_q <= lock_d;
    end
  end

  assign dis_o = dis_q;
  assign alt_o = alt_q;

  assert_user_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr_i && !mode_ok) |=> ($stable(dis_q) && $stable(alt_q)));

  generate
    for (genvar g = 0; g < NB; g++) begin : g_lock_chk
      assert_locked_byte_stable_R11: assert property (@(posedge clk) disable iff (!rst_ni)
        lock_q[g] |=> $stable(dis_q[g*8 +: 8]));
      assert_lock_never_drops_R11: assert property (@(posedge clk) disable iff (!rst_ni)
        !$fell(lock_q[g]));
    end
  endgenerate
endmodule

// File: rtl/rcr_route.sv
module rcr_route #(
  parameter int NR = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [NR-1:0] ev_i,
  input  logic [NR-1:0] flags_i,
  input  logic [NR-1:0] dis_i,
  input  logic [NR-1:0] alt_i,
  output logic          rst_req_o,
  output logic          safe_o,
  output logic          irq_o
);
  logic rst_q, rst_d;

  always_comb rst_d = |(ev_i & ~dis_i);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 1'b0;
    else         rst_q <= rst_d;
  end

  assign rst_req_o = rst_q;
  assign safe_o    = |(flags_i & dis_i & ~alt_i);
  assign irq_o     = |(flags_i & dis_i & alt_i);

  assert_irq_needs_disable_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o |-> (|(dis_i & alt_i)));
  assert_safe_needs_disable_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    safe_o |-> (|(dis_i & ~alt_i)));
  assert_rst_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_q |-> $past(|ev_i));
endmodule

// File: rtl/rst_cause_router.sv
module rst_cause_router
  import rcr_pkg::*;
#(
  parameter int NUM_FUNC = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwr_on_det,
  input  logic                  lv_core0_det,
  input  logic                  lv_core1_det,
  input  logic                  lv_reg_det,
  input  logic [NUM_FUNC-1:0]   func_evt,
  input  logic                  bus_wr,
  input  logic [1:0]            bus_mode,
  input  logic [1:0]            bus_addr,
  input  logic [(NUM_FUNC+1)/8-1:0] bus_be,
  input  logic [NUM_FUNC:0]     bus_wdata,
  output logic [NUM_FUNC:0]     bus_rdata,
  output logic                  func_rst_req,
  output logic                  safe_req,
  output logic                  irq_req
);
  localparam int NR = NUM_FUNC + 1;
  localparam int NB = NR / 8;

  logic [1:0]          rst_sync_q;
  logic                rst_i_n;
  logic [NR-1:0]       be_mask;
  logic                clr_ok;
  logic [PWR_W-1:0]    pwr_clr, pwr_flags;
  logic [NUM_FUNC-1:0] func_clr, func_flags;
  logic [NR-1:0]       route_ev, dis, alt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  generate
    for (genvar b = 0; b < NB; b++) begin : g_be
      assign be_mask[b*8 +: 8] = {8{bus_be[b]}};
    end
  endgenerate

  always_comb begin
    clr_ok   = bus_wr && (acc_mode_e'(bus_mode) == MODE_SUPV);
    pwr_clr  = (clr_ok && bus_addr == ADDR_PWR)  ? (bus_wdata[PWR_W-1:0] & be_mask[PWR_W-1:0]) : '0;
    func_clr = (clr_ok && bus_addr == ADDR_FUNC) ? (bus_wdata[NUM_FUNC-1:0] & be_mask[NUM_FUNC-1:0]) : '0;
  end

  rcr_capture #(.NUM_FUNC(NUM_FUNC)) u_capture (
    .clk          (clk),
    .rst_ni       (rst_i_n),
    .pwr_on_i     (pwr_on_det),
    .lv_c0_i      (lv_core0_det),
    .lv_c1_i      (lv_core1_det),
    .lv_reg_i     (lv_reg_det),
    .func_i       (func_evt),
    .pwr_clr_i    (pwr_clr),
    .func_clr_i   (func_clr),
    .pwr_flags_o  (pwr_flags),
    .func_flags_o (func_flags),
    .route_ev_o   (route_ev)
  );

  rcr_cfg #(.DW(NR)) u_cfg (
    .clk         (clk),
    .rst_ni      (rst_i_n),
    .bus_wr_i    (bus_wr),
    .bus_mode_i  (bus_mode),
    .bus_addr_i  (bus_addr),
    .bus_be_i    (bus_be),
    .bus_wdata_i (bus_wdata),
    .dis_o       (dis),
    .alt_o       (alt)
  );

  rcr_route #(.NR(NR)) u_route (
    .clk       (clk),
    .rst_ni    (rst_i_n),
    .ev_i      (route_ev),
    .flags_i   ({pwr_flags[BIT_LV0], func_flags}),
    .dis_i     (dis),
    .alt_i     (alt),
    .rst_req_o (func_rst_req),
    .safe_o    (safe_req),
    .irq_o     (irq_req)
  );

  always_comb begin
    case (bus_addr)
      ADDR_PWR:  bus_rdata = {{(NR-PWR_W){1'b0}}, pwr_flags};
      ADDR_FUNC: bus_rdata = {1'b0, func_flags};
      ADDR_DIS:  bus_rdata = dis;
      default:   bus_rdata = alt;
    endcase
  end
endmodule

// File: tb/tb_rst_cause_router.sv
module tb_rst_cause_router;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pwr_on_det, lv_core0_det, lv_core1_det, lv_reg_det;
  logic [14:0] func_evt;
  logic        bus_wr;
  logic [1:0]  bus_mode, bus_addr, bus_be;
  logic [15:0] bus_wdata, bus_rdata;
  logic        func_rst_req, safe_req, irq_req;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  rst_cause_router dut (
    .clk(clk), .rst_n(rst_n), .pwr_on_det(pwr_on_det), .lv_core0_det(lv_core0_det),
    .lv_core1_det(lv_core1_det), .lv_reg_det(lv_reg_det), .func_evt(func_evt),
    .bus_wr(bus_wr), .bus_mode(bus_mode), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .func_rst_req(func_rst_req),
    .safe_req(safe_req), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] m, input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
    bus_mode = m; bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [1:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic chk_out(input string req, input logic r, input logic s, input logic i);
    chk(req, {13'd0, func_rst_req, safe_req, irq_req}, {13'd0, r, s, i});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic t_reset(input string tag);
    chk_reg({tag, " power status"}, 2'd0, 16'h0);
    chk_reg({tag, " event status"}, 2'd1, 16'h0);
    chk_reg({tag, " disable"}, 2'd2, 16'h0);
    chk_reg({tag, " alternate"}, 2'd3, 16'h0);
    chk_out({tag, " outputs"}, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_power();
    pwr_on_det = 1'b1; step(); pwr_on_det = 1'b0; step();
    chk_reg("R2 power-on flag", 2'd0, 16'h0001);
    lv_core1_det = 1'b1; step(); lv_core1_det = 1'b0; step();
    chk_reg("R3 R4 domain1 clears power-on", 2'd0, 16'h0004);
    wr(2'd0, 2'd0, 2'b11, 16'h000F);
    chk_reg("R9 user clear ignored", 2'd0, 16'h0004);
    wr(2'd2, 2'd0, 2'b11, 16'h000F);
    chk_reg("R9 test clear ignored", 2'd0, 16'h0004);
    wr(2'd1, 2'd0, 2'b11, 16'h000F);
    chk_reg("R9 supervisor clear", 2'd0, 16'h0000);
    pwr_on_det = 1'b1; lv_reg_det = 1'b1; step();
    pwr_on_det = 1'b0; lv_reg_det = 1'b0; step();
    chk_reg("R3 R4 same-cycle regulator wins", 2'd0, 16'h0008);
    wr(2'd1, 2'd0, 2'b01, 16'h0008);
    chk_reg("R9 clear regulator flag", 2'd0, 16'h0000);
  endtask

  task automatic t_core0_reset();
    lv_core0_det = 1'b1; step();
    chk_reg("R5 no flag on assertion", 2'd0, 16'h0000);
    chk_out("R8 no request on assertion", 1'b0, 1'b0, 1'b0);
    step(2);
    lv_core0_det = 1'b0; step();
    chk_reg("R5 flag on deassertion", 2'd0, 16'h0002);
    chk_out("R8 reset request on deassertion", 1'b1, 1'b0, 1'b0);
    step();
    chk_out("R8 reset request one cycle", 1'b0, 1'b0, 1'b0);
    wr(2'd1, 2'd0, 2'b01, 16'h0002);
  endtask

  task automatic t_func_reset();
    func_evt[3] = 1'b1; step();
    chk_reg("R6 event flag", 2'd1, 16'h0008);
    chk_out("R6 reset pulse", 1'b1, 1'b0, 1'b0);
    step();
    chk_out("R6 pulse ends while line held", 1'b0, 1'b0, 1'b0);
    func_evt[3] = 1'b0;
    wr(2'd1, 2'd1, 2'b11, 16'h0008);
    chk_reg("R9 event flag cleared", 2'd1, 16'h0000);
  endtask

  task automatic t_config();
    wr(2'd0, 2'd2, 2'b11, 16'hFFFF);
    chk_reg("R10 user disable write ignored", 2'd2, 16'h0000);
    wr(2'd3, 2'd2, 2'b11, 16'hFFFF);
    chk_reg("R10 reserved mode write ignored", 2'd2, 16'h0000);
    wr(2'd1, 2'd2, 2'b01, 16'h0030);
    chk_reg("R10 supervisor disable write", 2'd2, 16'h0030);
    wr(2'd1, 2'd2, 2'b01, 16'h00FF);
    chk_reg("R11 low byte locked", 2'd2, 16'h0030);
    wr(2'd2, 2'd2, 2'b10, 16'h0000);
    wr(2'd1, 2'd2, 2'b10, 16'hFF00);
    chk_reg("R11 zero write locks high byte", 2'd2, 16'h0030);
    wr(2'd2, 2'd3, 2'b11, 16'h00FF);
    chk_reg("R10 test mode alternate write", 2'd3, 16'h00FF);
    wr(2'd1, 2'd3, 2'b11, 16'h0020);
    chk_reg("R11 alternate not locked", 2'd3, 16'h0020);
  endtask

  task automatic t_alternate();
    func_evt[4] = 1'b1; step(); func_evt[4] = 1'b0;
    chk_out("R7 disabled event to safe", 1'b0, 1'b1, 1'b0);
    func_evt[5] = 1'b1; step(); func_evt[5] = 1'b0;
    chk_out("R7 disabled event to irq", 1'b0, 1'b1, 1'b1);
    step(5);
    chk_out("R12 levels hold", 1'b0, 1'b1, 1'b1);
    wr(2'd0, 2'd1, 2'b11, 16'h0030);
    chk_reg("R9 user clear of event ignored", 2'd1, 16'h0030);
    wr(2'd1, 2'd1, 2'b01, 16'h0010);
    chk_out("R12 safe drops on clear", 1'b0, 1'b0, 1'b1);
    bus_mode = 2'd1; bus_addr = 2'd1; bus_be = 2'b01; bus_wdata = 16'h0020; bus_wr = 1'b1;
    func_evt[5] = 1'b1;
    step();
    bus_wr = 1'b0; func_evt[5] = 1'b0;
    chk_reg("R9 event beats clear", 2'd1, 16'h0020);
    chk_out("R9 irq kept", 1'b0, 1'b0, 1'b1);
    wr(2'd1, 2'd1, 2'b01, 16'h0020);
    chk_out("R12 irq drops on clear", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_core0_alt();
    wr(2'd1, 2'd2, 2'b10, 16'h8000);
    chk_reg("R11 lock reopened by power-on reset", 2'd2, 16'h8000);
    wr(2'd1, 2'd3, 2'b10, 16'h8000);
    lv_core0_det = 1'b1; step();
    chk_out("R8 no alternate on assertion", 1'b0, 1'b0, 1'b0);
    lv_core0_det = 1'b0; step();
    chk_out("R8 irq on deassertion", 1'b0, 1'b0, 1'b1);
    chk_reg("R5 flag set", 2'd0, 16'h0002);
    wr(2'd1, 2'd0, 2'b01, 16'h0002);
    chk_out("R12 irq drops with flag", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwr_on_det = 1'b0; lv_core0_det = 1'b0; lv_core1_det = 1'b0;
    lv_reg_det = 1'b0; func_evt = '0; bus_wr = 1'b0; bus_mode = 2'd0;
    bus_addr = 2'd0; bus_be = 2'b00; bus_wdata = '0;
    do_reset();
    t_reset("R1 first");
    t_power();
    t_core0_reset();
    t_func_reset();
    t_config();
    t_alternate();
    do_reset();
    t_reset("R1 second");
    t_core0_alt();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule